// File: doc/BRIEF.md
# Synchronous Serial Adapter Host-Side Glue

This block is the bus-facing control logic of a single-channel synchronous serial adapter. It watches a 16-bit I/O address and claims an aligned eight-byte window whose upper thirteen address bits match a strapped base setting. The low four bytes of the window are passed to the serial controller through a chip select and a two-bit register index. Two bytes hold local registers. The remaining two bytes are unused.

The setup register picks which controller request pin feeds each bus DMA request line, and it gates each line. It also chooses and enables one of three card interrupt sources. The link register drives the loopback controls and the clock-direction enables, and it can also be steered onto the controller's channel A sync input.

Routing is two-level. A source bit selects a pin and an enable bit gates the result. One setting would route the single channel A wait/request pin into both directions. The block treats that setting as illegal: it silences both request lines and sets a sticky error flag. When interrupt sharing is selected, the interrupt output is driven only while an interrupt is pending.

Top module: `sio_host_glue`

## Requirements
- R1: The window is hit when bus_addr[15:3] equals base_sel. ctl_cs is high only on a hit with bus_addr[2]=0 (offsets 0..3), and ctl_addr repeats bus_addr[1:0].
- R2: Setup register (offset 5). A write stores bits [5:0]. A read returns them with bits [7:6] always 0. The field layout is [5:4] interrupt source, [3] receive DMA gate, [2] transmit DMA gate, [1] receive source, [0] transmit source.
- R3: Link register (offset 4). A write stores bits [5:2]. A read returns bit 7 = test_mode_in, bits [5:2] as stored, and bits 6, 1 and 0 as 0.
- R4: After reset both registers read 0x00 (with test_mode_in low). Both request lines are low and dma_err is low.
- R5: drq_rx follows ctl_wreq_b when setup bit 1 is 1 and ctl_wreq_a when it is 0. It is forced low when setup bit 3 is 0.
- R6: drq_tx follows ctl_dtrreq_a when setup bit 0 is 1 and ctl_wreq_a when it is 0. It is forced low when setup bit 2 is 0.
- R7: When setup bits [3:0] = 4'b1100, both request lines are low regardless of the pins. dma_err then becomes 1 one clock later and stays 1 until reset.
- R8: The interrupt source code in setup [5:4] is 00 = none, 01 = tc_in, 10 = ctl_irq, 11 = test_mode_in. irq_out is high exactly when the selected source is high.
- R9: With share_mode=1, irq_oe is high only while an interrupt is pending. With share_mode=0, irq_oe is always 1.
- R10: The terminal-count source (code 01) raises an interrupt only when share_mode=1.
- R11: lpbk_local, lpbk_remote, rxclk_en and txclk_en follow link bits 5, 4, 3 and 2.
- R12: sync_a_out = link bit 4 AND sync_steer_en. lpbk_remote keeps following bit 4 in either case.
- R13: The following leave both registers unchanged: writes outside the window, and writes to offsets 0..3, 6 and 7. Reads of offsets 6 and 7 return 0 with rd_drive low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| base_sel | input | 13 | Strapped base, compared to bus_addr[15:3] |
| ctl_wreq_a | input | 1 | Controller channel A wait/request pin |
| ctl_dtrreq_a | input | 1 | Controller channel A DTR/request pin |
| ctl_wreq_b | input | 1 | Controller channel B wait/request pin |
| ctl_irq | input | 1 | Controller interrupt |
| tc_in | input | 1 | DMA terminal count |
| test_mode_in | input | 1 | Line test-mode indication |
| share_mode | input | 1 | Interrupt sharing selected |
| sync_steer_en | input | 1 | Route remote-loop bit to sync input |
| ctl_cs | output | 1 | Serial controller chip select |
| ctl_addr | output | 2 | Controller register index |
| rd_data | output | 8 | Read-back data |
| rd_drive | output | 1 | Block drives read data |
| drq_tx | output | 1 | Transmit DMA request |
| drq_rx | output | 1 | Receive DMA request |
| dma_err | output | 1 | Sticky illegal-routing flag |
| irq_out | output | 1 | Interrupt level |
| irq_oe | output | 1 | Interrupt output enable |
| lpbk_local | output | 1 | Local loopback control |
| lpbk_remote | output | 1 | Remote loopback control |
| rxclk_en | output | 1 | Receive clock enable |
| txclk_en | output | 1 | Transmit clock enable |
| sync_a_out | output | 1 | Channel A sync input drive |

## Verification
Request steering and the illegal-routing guard act in the same cycle, when a setup write lands on 4'b1100 while all three request pins are high. The bench first holds the pins high and then writes that setting. It checks that both request lines drop at once, and that the sticky flag is still clear right after the write edge and set one clock later. Interrupt selection and output enabling also coincide, when the terminal-count source is chosen and share_mode is flipped. Each flip is judged on both irq_out and irq_oe.

// File: rtl/sio_glue_pkg.sv
package sio_glue_pkg;

  typedef enum logic [1:0] {
    IRQ_NONE = 2'b00,
    IRQ_TC   = 2'b01,
    IRQ_CTL  = 2'b10,
    IRQ_TEST = 2'b11
  } irq_src_e;

  typedef struct packed {
    logic [1:0] rsv;
    irq_src_e   src;
    logic       rx_gate;
    logic       tx_gate;
    logic       rx_from_b;
    logic       tx_from_dtr;
  } setup_t;

  localparam logic [7:0] SETUP_WMASK = 8'h3F;
  localparam logic [7:0] LINK_WMASK  = 8'h3C;
  localparam int unsigned OFF_LINK   = 4;
  localparam int unsigned OFF_SETUP  = 5;

  // pin choice for each direction
  function automatic logic pick_tx(input setup_t s, input logic wa, input logic da);
    return s.tx_from_dtr ? da : wa;
  endfunction

  function automatic logic pick_rx(input setup_t s, input logic wa, input logic wb);
    return s.rx_from_b ? wb : wa;
  endfunction

  // shared channel A pin would feed both directions
  function automatic logic routing_clash(input setup_t s);
    return s.rx_gate && s.tx_gate && !s.rx_from_b && !s.tx_from_dtr;
  endfunction

endpackage

// File: rtl/sio_glue_decode.sv
module sio_glue_decode #(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 3,
  localparam int BASE_W = ADDR_W - WIN_W,
  localparam int NWIN   = 1 << WIN_W
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BASE_W-1:0] base_sel,
  output logic              hit,
  output logic [NWIN-1:0]   off_sel
);
  assign hit = (bus_addr[ADDR_W-1:WIN_W] == base_sel);

  for (genvar i = 0; i < NWIN; i++) begin : g_off
    assign off_sel[i] = hit && (bus_addr[WIN_W-1:0] == WIN_W'(i));
  end
endmodule

// File: rtl/sio_glue_regs.sv
module sio_glue_regs
  import sio_glue_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_setup,
  input  logic              wr_link,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] setup_q,
  output logic [DATA_W-1:0] link_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      link_q  <= '0;
    end else begin
      if (wr_setup) setup_q <= wdata & SETUP_WMASK;
      if (wr_link)  link_q  <= wdata & LINK_WMASK;
    end
  end

  // R13
  setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_setup |=> $stable(setup_q));
  // R13
  link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_link |=> $stable(link_q));
  // R2
  setup_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setup |=> (setup_q[5:0] == $past(wdata[5:0])));
endmodule

// File: rtl/sio_glue_dma.sv
module sio_glue_dma
  import sio_glue_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  setup_t setup,
  input  logic   pin_wreq_a,
  input  logic   pin_dtr_a,
  input  logic   pin_wreq_b,
  output logic   drq_tx,
  output logic   drq_rx,
  output logic   clash,
  output logic   err_q
);
  logic tx_raw, rx_raw;

  always_comb begin
    tx_raw = pick_tx(setup, pin_wreq_a, pin_dtr_a);
    rx_raw = pick_rx(setup, pin_wreq_a, pin_wreq_b);
    clash  = routing_clash(setup);
    drq_tx = setup.tx_gate && tx_raw && !clash;
    drq_rx = setup.rx_gate && rx_raw && !clash;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     err_q <= 1'b0;
    else if (clash) err_q <= 1'b1;
  end

  // R7
  clash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> (!drq_tx && !drq_rx));
  // R7
  clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> err_q);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R6
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !setup.tx_gate |-> !drq_tx);
  // R5
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !setup.rx_gate |-> !drq_rx);
endmodule

// File: rtl/sio_glue_irq.sv
module sio_glue_irq
  import sio_glue_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_src_e src,
  input  logic     tc_in,
  input  logic     ctl_irq,
  input  logic     test_mode_in,
  input  logic     share_mode,
  output logic     irq_pend,
  output logic     irq_out,
  output logic     irq_oe
);
  always_comb begin
    unique case (src)
      IRQ_TC:   irq_pend = tc_in && share_mode;
      IRQ_CTL:  irq_pend = ctl_irq;
      IRQ_TEST: irq_pend = test_mode_in;
      default:  irq_pend = 1'b0;
    endcase
    irq_out = irq_pend;
    irq_oe  = share_mode ? irq_pend : 1'b1;
  end

  // R9
  share_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (share_mode && !irq_out) |-> !irq_oe);
  // R9
  dedicated_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !share_mode |-> irq_oe);
  // R10
  tc_share_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == IRQ_TC && !share_mode) |-> !irq_out);
  // R8
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == IRQ_NONE) |-> !irq_out);
endmodule

// File: rtl/sio_host_glue.sv
module sio_host_glue
  import sio_glue_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 3,
  parameter int DATA_W = 8,
  localparam int BASE_W = ADDR_W - WIN_W,
  localparam int NWIN   = 1 << WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [BASE_W-1:0] base_sel,
  input  logic              ctl_wreq_a,
  input  logic              ctl_dtrreq_a,
  input  logic              ctl_wreq_b,
  input  logic              ctl_irq,
  input  logic              tc_in,
  input  logic              test_mode_in,
  input  logic              share_mode,
  input  logic              sync_steer_en,
  output logic              ctl_cs,
  output logic [1:0]        ctl_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              drq_tx,
  output logic              drq_rx,
  output logic              dma_err,
  output logic              irq_out,
  output logic              irq_oe,
  output logic              lpbk_local,
  output logic              lpbk_remote,
  output logic              rxclk_en,
  output logic              txclk_en,
  output logic              sync_a_out
);
  logic              hit;
  logic [NWIN-1:0]   off_sel;
  logic              wr_setup, wr_link;
  logic [DATA_W-1:0] setup_q, link_q, link_rb;
  setup_t            setup;
  logic              clash, irq_pend;

  sio_glue_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) dec_i (
    .bus_addr(bus_addr), .base_sel(base_sel), .hit(hit), .off_sel(off_sel));

  assign wr_setup = io_wr && off_sel[OFF_SETUP];
  assign wr_link  = io_wr && off_sel[OFF_LINK];

  sio_glue_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_setup(wr_setup), .wr_link(wr_link),
    .wdata(bus_wdata), .setup_q(setup_q), .link_q(link_q));

  assign setup = setup_t'(setup_q);

  sio_glue_dma dma_i (
    .clk(clk), .rst_n(rst_n), .setup(setup),
    .pin_wreq_a(ctl_wreq_a), .pin_dtr_a(ctl_dtrreq_a), .pin_wreq_b(ctl_wreq_b),
    .drq_tx(drq_tx), .drq_rx(drq_rx), .clash(clash), .err_q(dma_err));

  sio_glue_irq irq_i (
    .clk(clk), .rst_n(rst_n), .src(setup.src), .tc_in(tc_in), .ctl_irq(ctl_irq),
    .test_mode_in(test_mode_in), .share_mode(share_mode),
    .irq_pend(irq_pend), .irq_out(irq_out), .irq_oe(irq_oe));

  assign ctl_cs   = hit && !bus_addr[WIN_W-1];
  assign ctl_addr = bus_addr[1:0];

  assign link_rb  = link_q | {test_mode_in, {(DATA_W-1){1'b0}}};
  assign rd_drive = io_rd && (off_sel[OFF_LINK] || off_sel[OFF_SETUP]);

  always_comb begin
    rd_data = '0;
    if (io_rd && off_sel[OFF_LINK])  rd_data = link_rb;
    if (io_rd && off_sel[OFF_SETUP]) rd_data = setup_q;
  end

  assign lpbk_local  = link_q[5];
  assign lpbk_remote = link_q[4];
  assign rxclk_en    = link_q[3];
  assign txclk_en    = link_q[2];
  assign sync_a_out  = link_q[4] && sync_steer_en;

  // R1
  cs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_cs |-> (bus_addr[ADDR_W-1:WIN_W] == base_sel && bus_addr[2] == 1'b0));
  // R12
  sync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_a_out |-> lpbk_remote);
  // R9
  pend_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> (irq_oe && irq_out));
  // R7
  clash_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> dma_err);
endmodule

// File: tb/sio_host_glue_tb.sv
module sio_host_glue_tb_top;
  localparam int CLK_P = 10;
  localparam logic [15:0] BASE = 16'h0300;

  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic io_rd = 0, io_wr = 0;
  logic wa = 0, da = 0, wb = 0, ctl_irq = 0, tc_in = 0, tmode = 0;
  logic share = 0, steer = 0;
  logic ctl_cs, rd_drive, drq_tx, drq_rx, dma_err, irq_out, irq_oe;
  logic lpl, lpr, rxc, txc, sync_a;
  logic [1:0] ctl_addr;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  sio_host_glue dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .base_sel(BASE[15:3]),
    .ctl_wreq_a(wa), .ctl_dtrreq_a(da), .ctl_wreq_b(wb), .ctl_irq(ctl_irq),
    .tc_in(tc_in), .test_mode_in(tmode), .share_mode(share), .sync_steer_en(steer),
    .ctl_cs(ctl_cs), .ctl_addr(ctl_addr), .rd_data(rd_data), .rd_drive(rd_drive),
    .drq_tx(drq_tx), .drq_rx(drq_rx), .dma_err(dma_err), .irq_out(irq_out),
    .irq_oe(irq_oe), .lpbk_local(lpl), .lpbk_remote(lpr), .rxclk_en(rxc),
    .txclk_en(txc), .sync_a_out(sync_a));

  // {setup[3:0], wa, da, wb, exp_tx, exp_rx}
  localparam logic [8:0] VEC [13] = '{
    {4'b0000, 3'b111, 2'b00}, {4'b0100, 3'b100, 2'b10}, {4'b0100, 3'b010, 2'b00},
    {4'b0101, 3'b010, 2'b10}, {4'b0101, 3'b100, 2'b00}, {4'b1000, 3'b100, 2'b01},
    {4'b1010, 3'b001, 2'b01}, {4'b1010, 3'b100, 2'b00}, {4'b1101, 3'b110, 2'b11},
    {4'b1110, 3'b101, 2'b11}, {4'b1111, 3'b011, 2'b11}, {4'b1111, 3'b100, 2'b00},
    {4'b1001, 3'b001, 2'b00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; io_rd = 1;
    #1 v = rd_data;
    io_rd = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4 reset state
    rd(BASE + 5, v); chk("R4 setup reset", v, 8'h00);
    rd(BASE + 4, v); chk("R4 link reset", v, 8'h00);
    chk("R4 drq/err reset", {5'b0, drq_tx, drq_rx, dma_err}, 8'h00);

    // R1 decode
    @(negedge clk); bus_addr = BASE + 2; #1;
    chk("R1 cs at offset 2", {6'b0, ctl_addr}, 8'h02);
    chk("R1 cs asserted", {7'b0, ctl_cs}, 8'h01);
    bus_addr = BASE + 4; #1; chk("R1 no cs at offset 4", {7'b0, ctl_cs}, 8'h00);
    bus_addr = BASE ^ 16'h0100; #1; chk("R1 no cs off window", {7'b0, ctl_cs}, 8'h00);

    // R5 R6 steering table
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); wa = VEC[i][4]; da = VEC[i][3]; wb = VEC[i][2];
      wr(BASE + 5, {4'h0, VEC[i][8:5]});
      chk($sformatf("R5/R6 vector %0d", i), {6'b0, drq_tx, drq_rx}, {6'b0, VEC[i][1:0]});
    end
    chk("R7 no error before clash", {7'b0, dma_err}, 8'h00);

    // R7 clash with all pins high
    @(negedge clk); wa = 1; da = 1; wb = 1;
    bus_addr = BASE + 5; bus_wdata = 8'h0C; io_wr = 1;
    @(posedge clk); #1;
    chk("R7 clash silences drq", {6'b0, drq_tx, drq_rx}, 8'h00);
    chk("R7 flag not yet set", {7'b0, dma_err}, 8'h00);
    @(negedge clk); io_wr = 0;
    @(negedge clk); chk("R7 flag set", {7'b0, dma_err}, 8'h01);
    wr(BASE + 5, 8'h0F);
    chk("R7 flag sticky", {7'b0, dma_err}, 8'h01);
    chk("R5/R6 legal after clash", {6'b0, drq_tx, drq_rx}, 8'h03);

    // R2 readback
    wr(BASE + 5, 8'hFF); rd(BASE + 5, v); chk("R2 reserved bits zero", v, 8'h3F);
    wr(BASE + 5, 8'h16); rd(BASE + 5, v); chk("R2 readback", v, 8'h16);

    // R13 ignored writes
    wr(BASE ^ 16'h0100 | 16'h0005, 8'h21); rd(BASE + 5, v); chk("R13 off-window write", v, 8'h16);
    wr(BASE + 6, 8'h21); wr(BASE + 1, 8'h21); rd(BASE + 5, v); chk("R13 offsets 6/1 write", v, 8'h16);
    rd(BASE + 4, v); chk("R13 link untouched", v, 8'h00);
    @(negedge clk); bus_addr = BASE + 7; io_rd = 1; #1;
    chk("R13 offset 7 read", rd_data, 8'h00);
    chk("R13 offset 7 no drive", {7'b0, rd_drive}, 8'h00);
    io_rd = 0;

    // R3 R11 link register
    wr(BASE + 4, 8'hFF); rd(BASE + 4, v); chk("R3 link readback", v, 8'h3C);
    tmode = 1; rd(BASE + 4, v); chk("R3 test status bit", v, 8'hBC); tmode = 0;
    wr(BASE + 4, 8'h24);
    chk("R11 outputs", {4'b0, lpl, lpr, rxc, txc}, 8'h09);
    // R12 sync steering
    wr(BASE + 4, 8'h10);
    chk("R12 steer off", {6'b0, lpr, sync_a}, 8'h02);
    @(negedge clk); steer = 1; #1;
    chk("R12 steer on", {6'b0, lpr, sync_a}, 8'h03);

    // R8 R9 R10 interrupts
    wr(BASE + 5, 8'h00); ctl_irq = 1; tc_in = 1; tmode = 1; #1;
    chk("R8 none source", {6'b0, irq_out, irq_oe}, 8'h01);
    wr(BASE + 5, 8'h20); ctl_irq = 0; #1;
    chk("R8 ctl source low", {7'b0, irq_out}, 8'h00);
    ctl_irq = 1; #1; chk("R8 ctl source high", {7'b0, irq_out}, 8'h01);
    wr(BASE + 5, 8'h30); #1; chk("R8 test source", {7'b0, irq_out}, 8'h01);
    wr(BASE + 5, 8'h10); #1;
    chk("R10 tc dedicated", {6'b0, irq_out, irq_oe}, 8'h01);
    share = 1; #1; chk("R10 tc shared", {6'b0, irq_out, irq_oe}, 8'h03);
    tc_in = 0; #1; chk("R9 float idle", {6'b0, irq_out, irq_oe}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule